// File: doc/BRIEF.md
# Reloadable Up/Down Event Counter

This block is a single 16-bit counter channel that counts edges of an external event input. It divides the rate of those edges by a programmable ratio. A reload value `n` is written through a small register write port. Each time the counter wraps, it reloads `n`, raises a one-cycle interrupt request and, if enabled, toggles a pulse output. A wrap is an underflow below zero when counting down, or an overflow above the all-ones value when counting up.

The count direction has two possible sources. It can come from a software direction bit, or from the synchronized level of a dedicated direction pin. A mode register selects which one is used. The mode register also selects the counted edge (rising or falling), enables the pulse output and starts or stops counting. Both the event input and the direction pin pass through a two-flop synchronizer before use. The selected edge is then detected against one registered sample.

Top module: `evt_divider`

## Requirements
- R1: After reset, `irq` and `pulse_out` are 0 and the counter is stopped, so input edges produce no interrupt until counting is started.
- R2: Write port encoding. `wr_sel`=0 writes the full reload value. `wr_sel`=1 writes the mode: bit0 is edge polarity, bit1 is direction source, bit2 is pulse enable and bit3 is run. `wr_sel`=2 bit0 writes the software direction. A write with `wr_sel`=3 changes nothing.
- R3: With the polarity bit at 1, only rising edges of `evt_in` are counted. With it at 0, only falling edges are counted.
- R4: When counting down, one interrupt is raised every n+1 counted edges, for any reload value n.
- R5: When counting up, one interrupt is raised every 65535−n+1 counted edges.
- R6: With the direction source bit at 0, the software direction bit sets the direction (1 = up, 0 = down). With the source bit at 1, the synchronized `dir_in` level sets it (1 = up, 0 = down).
- R7: Each wrap raises `irq` for exactly one cycle. `irq` is high during the cycle after the third rising clock edge following the input change that formed the counted edge.
- R8: With pulse enable at 1, `pulse_out` toggles on every wrap. With pulse enable at 0, `pulse_out` is held at 0.
- R9: Writing run=1 while the counter is stopped loads the current reload value into the counter.
- R10: While run is 0, counted edges do not change the counter and raise no interrupt.
- R11: A reload write while the counter runs does not disturb the count in progress. The new value is used from the next wrap on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 reload, 1 mode, 2 direction) |
| wr_data | input | 16 | Write data |
| evt_in | input | 1 | External event input (asynchronous) |
| dir_in | input | 1 | External direction pin, 1 = up (asynchronous) |
| irq | output | 1 | One-cycle interrupt request on each wrap |
| pulse_out | output | 1 | Toggle output on each wrap when enabled |

## Verification
An input change applied at a falling clock edge reaches the interrupt after three rising edges: two synchronizer stages, then the counter and interrupt register. `irq` is therefore seen at the third falling edge after the change. The bench holds every event level for six cycles and counts interrupts at falling edges, so each counted edge has settled before the next is driven. One test steps cycle by cycle after a single edge and expects `irq` exactly at the third falling edge and low at the fourth. Division checks sweep reload values near both ends of the range in both directions. The bench compares the interrupt total after period−1 edges, after period edges and after two periods with a period it computes from n.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_DIR    = 2'd2,
    SEL_NONE   = 2'd3
  } evc_sel_e;

  // mode register bit positions (R2)
  localparam int MODE_POL   = 0;
  localparam int MODE_SRC   = 1;
  localparam int MODE_PULSE = 2;
  localparam int MODE_RUN   = 3;

  typedef struct packed {
    logic run;
    logic pulse_en;
    logic dir_from_pin;
    logic pol_rise;
  } evc_cfg_t;

endpackage

// File: rtl/evc_sync_edge.sv
module evc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  input  logic dir_in,
  input  logic pol_rise,
  output logic edge_hit,
  output logic dir_sync
);
  logic [STAGES-1:0] evt_sh;
  logic [STAGES-1:0] dir_sh;
  logic              evt_prev;
  logic              evt_s;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            evt_sh[0] <= 1'b0;
            dir_sh[0] <= 1'b0;
          end else begin
            evt_sh[0] <= evt_in;
            dir_sh[0] <= dir_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            evt_sh[g] <= 1'b0;
            dir_sh[g] <= 1'b0;
          end else begin
            evt_sh[g] <= evt_sh[g-1];
            dir_sh[g] <= dir_sh[g-1];
          end
        end
      end
    end
  endgenerate

  assign evt_s    = evt_sh[STAGES-1];
  assign dir_sync = dir_sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_prev <= 1'b0;
    else        evt_prev <= evt_s;
  end

  always_comb begin
    if (pol_rise) edge_hit = evt_s & ~evt_prev;
    else          edge_hit = ~evt_s & evt_prev;
  end

  // R3
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |-> (evt_s != evt_prev));
endmodule

// File: rtl/evc_regs.sv
module evc_regs
  import evc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output evc_cfg_t     cfg,
  output logic [W-1:0] reload,
  output logic         sw_up,
  output logic         start
);
  logic sel_reload, sel_mode, sel_dir;

  assign sel_reload = wr_en && (evc_sel_e'(wr_sel) == SEL_RELOAD);
  assign sel_mode   = wr_en && (evc_sel_e'(wr_sel) == SEL_MODE);
  assign sel_dir    = wr_en && (evc_sel_e'(wr_sel) == SEL_DIR);

  // run rising from a stopped state loads the counter (R9)
  assign start = sel_mode && wr_data[MODE_RUN] && !cfg.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      reload <= '0;
      sw_up  <= 1'b0;
    end else begin
      if (sel_reload) reload <= wr_data;
      if (sel_mode) begin
        cfg.pol_rise     <= wr_data[MODE_POL];
        cfg.dir_from_pin <= wr_data[MODE_SRC];
        cfg.pulse_en     <= wr_data[MODE_PULSE];
        cfg.run          <= wr_data[MODE_RUN];
      end
      if (sel_dir) sw_up <= wr_data[0];
    end
  end

  // R2
  none_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> ($stable(cfg) && $stable(reload) && $stable(sw_up)));
endmodule

// File: rtl/evc_core.sv
module evc_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         run,
  input  logic         count_hit,
  input  logic         up,
  input  logic         pulse_en,
  input  logic [W-1:0] reload,
  output logic         irq,
  output logic         pulse_out
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt;
  logic [W:0]   nxt;
  logic         step_en;
  logic         wrap_evt;

  // one step: msb flags a wrap, low bits carry the next count
  function automatic logic [W:0] step_fn(input logic [W-1:0] c,
                                         input logic         go_up,
                                         input logic [W-1:0] n);
    if (go_up) return (c == MAXV)  ? {1'b1, n} : {1'b0, c + 1'b1};
    else       return (c == '0)    ? {1'b1, n} : {1'b0, c - 1'b1};
  endfunction

  assign nxt      = step_fn(cnt, up, reload);
  assign step_en  = run && count_hit && !start;
  assign wrap_evt = step_en && nxt[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      irq       <= 1'b0;
      pulse_out <= 1'b0;
    end else begin
      if (start)        cnt <= reload;
      else if (step_en) cnt <= nxt[W-1:0];
      irq       <= wrap_evt;
      pulse_out <= pulse_en ? (pulse_out ^ wrap_evt) : 1'b0;
    end
  end

  // R4
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count_hit && !start && !up && cnt == '0) |=> (irq && cnt == $past(reload)));
  // R5
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count_hit && !start && up && cnt == MAXV) |=> (irq && cnt == $past(reload)));
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(run && count_hit));
  // R8
  pulse_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pulse_en) |-> !pulse_out);
  // R8
  pulse_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pulse_en) |-> ((pulse_out != $past(pulse_out)) == irq));
  // R9
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == $past(reload)));
  // R10
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> ($stable(cnt) && !irq));
endmodule

// File: rtl/evt_divider.sv
module evt_divider
  import evc_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         evt_in,
  input  logic         dir_in,
  output logic         irq,
  output logic         pulse_out
);
  evc_cfg_t     cfg;
  logic [W-1:0] reload;
  logic         sw_up, start, edge_hit, dir_sync, up;

  evc_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg(cfg), .reload(reload), .sw_up(sw_up), .start(start)
  );

  evc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .dir_in(dir_in),
    .pol_rise(cfg.pol_rise), .edge_hit(edge_hit), .dir_sync(dir_sync)
  );

  // R6 direction source select
  assign up = cfg.dir_from_pin ? dir_sync : sw_up;

  evc_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .run(cfg.run), .count_hit(edge_hit),
    .up(up), .pulse_en(cfg.pulse_en), .reload(reload), .irq(irq), .pulse_out(pulse_out)
  );
endmodule

// File: tb/evt_divider_bench.sv
`timescale 1ns/1ps
module evt_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        evt_in = 1'b0;
  logic        dir_in = 1'b0;
  logic        irq, pulse_out;
  int          errs = 0, checks = 0, irq_cnt = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  evt_divider u_evt_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .evt_in(evt_in), .dir_in(dir_in), .irq(irq), .pulse_out(pulse_out)
  );

  always @(negedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // k full pulses: one rising and one falling edge each
  task automatic feed(input int k);
    for (int i = 0; i < k; i++) begin
      evt_in = 1'b1; settle();
      evt_in = 1'b0; settle();
    end
  endtask

  // mode value: bit0 pol, bit1 src, bit2 pulse, bit3 run
  task automatic run_case(input bit upd, input int n, input bit pen, input string req);
    int per, base;
    per = upd ? (65536 - n) : (n + 1);
    wr(2'd0, 16'(n));
    wr(2'd2, {15'd0, upd});
    wr(2'd1, {12'd0, 1'b1, pen, 1'b0, 1'b1});
    base = irq_cnt;
    feed(per - 1);
    chk(req, irq_cnt - base, 0);
    feed(1);
    chk(req, irq_cnt - base, 1);
    chk("R8", pulse_out, pen ? 1 : 0);
    feed(per);
    chk(req, irq_cnt - base, 2);
    chk("R8", pulse_out, 0);
    wr(2'd1, {12'd0, 1'b0, pen, 2'b00});
  endtask

  initial begin
    int base, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", irq, 0);
    chk("R1", pulse_out, 0);
    feed(3);
    chk("R1", irq_cnt, 0);

    // R4 down sweep, R5 up sweep
    for (int n = 0; n < 10; n++) run_case(1'b0, n, 1'b1, "R4");
    for (int n = 65526; n < 65536; n++) run_case(1'b1, n, 1'b1, "R5");
    run_case(1'b0, 2, 1'b0, "R8");

    // R7 latency and single-cycle width
    wr(2'd0, 16'd0); wr(2'd2, 16'd0); wr(2'd1, 16'h0009);
    @(negedge clk); evt_in = 1'b1; seen = 0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (irq && seen == 0) seen = i;
      if (i == 4) chk("R7", irq, 0);
    end
    chk("R7", seen, 3);
    settle();

    // R3 polarity: rising counted, falling not (n=0 down: each edge wraps)
    base = irq_cnt;
    evt_in = 1'b0; settle();
    chk("R3", irq_cnt - base, 0);
    evt_in = 1'b1; settle();
    chk("R3", irq_cnt - base, 1);
    wr(2'd1, 16'h0000); wr(2'd1, 16'h0008);
    base = irq_cnt;
    evt_in = 1'b0; settle();
    chk("R3", irq_cnt - base, 1);
    evt_in = 1'b1; settle();
    chk("R3", irq_cnt - base, 1);
    evt_in = 1'b0; settle();
    wr(2'd1, 16'h0000);

    // R6 direction from pin; software bit says down
    wr(2'd0, 16'hFFFD); wr(2'd2, 16'd0);
    dir_in = 1'b1; settle();
    wr(2'd1, 16'h000B);
    base = irq_cnt;
    feed(3);
    chk("R6", irq_cnt - base, 1);
    wr(2'd1, 16'h0000);
    dir_in = 1'b0; settle();
    wr(2'd1, 16'h000B);
    base = irq_cnt;
    feed(3);
    chk("R6", irq_cnt - base, 0);
    wr(2'd1, 16'h0000);
    // software up with pin low and source = bit
    wr(2'd2, 16'd1); wr(2'd1, 16'h0009);
    base = irq_cnt;
    feed(3);
    chk("R6", irq_cnt - base, 1);
    wr(2'd1, 16'h0000);

    // R10 stopped counter ignores edges, R9 restart reloads
    wr(2'd2, 16'd0); wr(2'd0, 16'd3); wr(2'd1, 16'h0009);
    base = irq_cnt;
    feed(2);
    wr(2'd1, 16'h0001);
    feed(5);
    chk("R10", irq_cnt - base, 0);
    wr(2'd1, 16'h0009);
    feed(3);
    chk("R9", irq_cnt - base, 0);
    feed(1);
    chk("R9", irq_cnt - base, 1);

    // R2 select 3 write changes nothing
    wr(2'd3, 16'h0000);
    feed(3);
    chk("R2", irq_cnt - base, 1);
    feed(1);
    chk("R2", irq_cnt - base, 2);

    // R11 reload write mid-count (period 2 -> 5)
    wr(2'd1, 16'h0001); wr(2'd0, 16'd1); wr(2'd1, 16'h0009);
    base = irq_cnt;
    feed(1);
    wr(2'd0, 16'd4);
    feed(1);
    chk("R11", irq_cnt - base, 1);
    feed(4);
    chk("R11", irq_cnt - base, 1);
    feed(1);
    chk("R11", irq_cnt - base, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule